// File: doc/BRIEF.md
# Dual-Mode Fractional Clock-Enable Divider

This block turns a module clock into a stream of single-cycle enable strobes. Its rate is set by a 10-bit step value. In reload mode the block divides by the integer 1024 minus the step. In fractional mode the step is added to a 10-bit accumulator on every cycle, and a strobe is produced on each carry out of the top bit. This gives an average rate of step/1024 of the input clock. A single 10-bit adder does the work in both modes.

A 32-bit register holds the configuration and shows the live accumulator. A write strobe updates the register, and the read data is always presented.

Downstream logic can pause the divider through a suspend request and acknowledge pair. There are two ways to enter suspend. In immediate entry the divider stops at once. In granted entry it runs until it produces its next strobe. A software disable bit can stop the divider. When hardware control is enabled, an external enable pin governs it instead.

Top module: `frac_clk_div`

## Requirements
- R1: After a synchronous active-low reset the register reads 0x03FF43FF: step 0x3FF, reload mode, accumulator 0x3FF, all other fields zero.
- R2: The register layout is as follows. The step is bits [9:0]. The immediate-suspend select is bit 11 (1 = immediate, 0 = granted). The suspend control is bits [13:12]. The divider mode is bits [15:14]. The accumulator is bits [25:16]. The suspend acknowledge is bit 28. The live suspend request is bit 29. The hardware-control enable is bit 30. The software disable is bit 31. Bits 10, 26 and 27 read 0. Writes to bits 10, 16 to 29 and 26 to 27 have no effect.
- R3: The accumulator takes the newly written step on the clock edge that stores the write. No strobe is produced on that edge, and the acknowledge is cleared.
- R4: In reload mode (mode 01) the accumulator advances by one per running cycle. When it wraps past 1023 it reloads with the step and a strobe is produced. The strobe period is therefore 1024 minus the step; a step of 1023 gives a strobe every cycle.
- R5: In fractional mode (mode 10) the step is added to the accumulator on every running cycle, and a strobe is produced on each carry out of bit 9.
- R6: With mode 00 or 11 no strobe is produced and the accumulator holds its value.
- R7: With hardware control off, a disable bit of 1 stops the divider. With hardware control on, the divider runs exactly when the external enable pin is 1, whatever the disable bit holds. A stopped divider holds its accumulator and produces no strobe.
- R8: With suspend control 00 the suspend request is ignored and the acknowledge stays 0.
- R9: In immediate entry with a nonzero suspend control, the acknowledge rises on the first edge that sees the request. That edge and every later edge with the acknowledge high neither advance the accumulator nor produce a strobe.
- R10: In granted entry with a nonzero suspend control, the divider keeps running while the request is high. The acknowledge rises on the same edge as the next strobe, and the divider is frozen from then on.
- R11: The acknowledge falls on the first edge that sees the request low. The divider resumes counting on the edge after that.
- R12: The strobe output is registered and is high for exactly one cycle per carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, always valid |
| susp_req_i | input | 1 | Suspend request |
| susp_ack_o | output | 1 | Suspend acknowledge |
| hw_en_i | input | 1 | External clock enable, used when hardware control is on |
| tick_o | output | 1 | Single-cycle clock-enable strobe |

## Verification
A wrong accumulator value appears at the ports in two ways. The readback field shows it on the very next cycle. The strobe spacing shows it within one divide period, which is at most 1024 cycles. A broken suspend state shows up on the acknowledge output within one edge of the request changing, and as strobes that appear while the acknowledge is high. The bench keeps a per-cycle model of the accumulator and the handshake. It compares both the strobe and the acknowledge on every cycle, so any one-cycle slip in either is reported where it happens.

// File: rtl/fdiv_pkg.sv
// Package: shared widths, register bit positions and types for the
// fractional clock-enable divider. Assumes a 32-bit register word.
package fdiv_pkg;
    localparam int ACC_W    = 10;
    localparam int REG_W    = 32;
    localparam int ACC_LSB  = 16;
    localparam int ACC_MSB  = ACC_LSB + ACC_W - 1;

    typedef enum logic [1:0] {
        DM_OFF0   = 2'b00,
        DM_RELOAD = 2'b01,
        DM_FRAC   = 2'b10,
        DM_OFF1   = 2'b11
    } dmode_e;

    typedef struct packed {
        logic             dis;
        logic             hwen;
        dmode_e           dmode;
        logic [1:0]       scfg;
        logic             imm;
        logic [ACC_W-1:0] step;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{dis: 1'b0, hwen: 1'b0, dmode: DM_RELOAD,
                                   scfg: 2'b00, imm: 1'b0, step: '1};
endpackage

// File: rtl/fdiv_regs.sv
// Module: fdiv_regs
// Holds the writable configuration fields and assembles the read word.
// Assumes wr_en is a single-cycle strobe; read-only bits in wdata are dropped.
module fdiv_regs
    import fdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic [ACC_W-1:0] acc,
    input  logic             req,
    input  logic             ack,
    output cfg_t             cfg,
    output logic [REG_W-1:0] rdata
);
    cfg_t cfg_q;
    logic unused_ro;

    assign unused_ro = ^{wdata[29:ACC_LSB], wdata[ACC_W]};

    // Store the writable fields on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en) begin
            cfg_q.dis   <= wdata[31];
            cfg_q.hwen  <= wdata[30];
            cfg_q.dmode <= dmode_e'(wdata[15:14]);
            cfg_q.scfg  <= wdata[13:12];
            cfg_q.imm   <= wdata[11];
            cfg_q.step  <= wdata[ACC_W-1:0];
        end
    end

    // Assemble the read word from configuration and live status.
    always_comb begin
        rdata                  = '0;
        rdata[31]              = cfg_q.dis;
        rdata[30]              = cfg_q.hwen;
        rdata[29]              = req;
        rdata[28]              = ack;
        rdata[ACC_MSB:ACC_LSB] = acc;
        rdata[15:14]           = cfg_q.dmode;
        rdata[13:12]           = cfg_q.scfg;
        rdata[11]              = cfg_q.imm;
        rdata[ACC_W-1:0]       = cfg_q.step;
    end

    assign cfg = cfg_q;

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));
endmodule

// File: rtl/fdiv_core.sv
// Module: fdiv_core
// Shared-adder accumulator. In reload mode it adds one and reloads the step
// on wrap; in fractional mode it adds the step. Emits a registered strobe on carry.
// Assumes run is only high in an active mode.
module fdiv_core
    import fdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACC_W-1:0] load_step,
    input  logic [ACC_W-1:0] step,
    input  logic             frac,
    input  logic             run,
    output logic [ACC_W-1:0] acc_o,
    output logic             carry_o,
    output logic             tick_o
);
    logic [ACC_W-1:0] acc_q;
    logic             tick_q;
    logic [ACC_W-1:0] addend;
    logic [ACC_W:0]   sum;

    // Single adder: increment in reload mode, step in fractional mode.
    always_comb begin
        addend  = frac ? step : ACC_W'(1);
        sum     = {1'b0, acc_q} + {1'b0, addend};
        carry_o = sum[ACC_W];
    end

    // Advance the accumulator and register the carry strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '1;
            tick_q <= 1'b0;
        end else if (load) begin
            acc_q  <= load_step;
            tick_q <= 1'b0;
        end else if (run) begin
            acc_q  <= (!frac && carry_o) ? step : sum[ACC_W-1:0];
            tick_q <= carry_o;
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign acc_o  = acc_q;
    assign tick_o = tick_q;

    // R3
    load_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc_q == $past(load_step)) && !tick_q);
    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(acc_q) && !tick_q);
endmodule

// File: rtl/fdiv_susp.sv
// Module: fdiv_susp
// Decides whether the divider runs this cycle (mode, clock gating,
// suspend) and keeps the suspend acknowledge register.
// Assumes carry is the raw adder carry of the current accumulator.
module fdiv_susp
    import fdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg,
    input  logic load,
    input  logic req,
    input  logic hw_en,
    input  logic carry,
    output logic run,
    output logic ack
);
    logic ack_q;
    logic ack_d;
    logic clk_ok;
    logic mode_on;
    logic susp_on;

    // Gate the divider on mode, enable source and suspend state.
    always_comb begin
        clk_ok  = cfg.hwen ? hw_en : !cfg.dis;
        mode_on = (cfg.dmode == DM_RELOAD) || (cfg.dmode == DM_FRAC);
        susp_on = (cfg.scfg != 2'b00);
        run     = mode_on && clk_ok && !ack_q && !(susp_on && cfg.imm && req);
    end

    // Next acknowledge: immediate on request, granted on the next strobe.
    always_comb begin
        if (load || !susp_on || !req) ack_d = 1'b0;
        else if (ack_q)               ack_d = 1'b1;
        else if (cfg.imm)             ack_d = 1'b1;
        else                          ack_d = run && carry;
    end

    // Register the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= ack_d;
    end

    assign ack = ack_q;

    // R8
    ignore_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !susp_on |=> !ack_q);
    // R9
    imm_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_on && cfg.imm && req && !load) |=> ack_q);
    // R11
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !ack_q);
endmodule

// File: rtl/frac_clk_div.sv
// Module: frac_clk_div
// Top of the dual-mode fractional clock-enable divider: register,
// shared-adder core and suspend/gating control.
// Assumes all inputs are synchronous to clk.
module frac_clk_div
    import fdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             susp_req_i,
    output logic             susp_ack_o,
    input  logic             hw_en_i,
    output logic             tick_o
);
    cfg_t             cfg;
    logic [ACC_W-1:0] acc;
    logic             carry;
    logic             run;

    fdiv_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .wdata (wdata),
        .acc   (acc),
        .req   (susp_req_i),
        .ack   (susp_ack_o),
        .cfg   (cfg),
        .rdata (rdata)
    );

    fdiv_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_en),
        .load_step (wdata[ACC_W-1:0]),
        .step      (cfg.step),
        .frac      (cfg.dmode == DM_FRAC),
        .run       (run),
        .acc_o     (acc),
        .carry_o   (carry),
        .tick_o    (tick_o)
    );

    fdiv_susp u_susp (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg   (cfg),
        .load  (wr_en),
        .req   (susp_req_i),
        .hw_en (hw_en_i),
        .carry (carry),
        .run   (run),
        .ack   (susp_ack_o)
    );

    // R10
    granted_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(susp_ack_o) && !cfg.imm) |-> tick_o);
    // R12
    frozen_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_ack_o && !wr_en) |=> !tick_o);
endmodule

// File: tb/frac_clk_div_test.sv
// Bench: scoreboard. The driver steps a requirement-level model each cycle
// and queues the expected strobe/acknowledge; the monitor compares after each edge.
module frac_clk_div_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        req = 1'b0;
    logic        ack;
    logic        hw_en = 1'b0;
    logic        tick;

    int checks = 0;
    int errors = 0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    // model state
    logic [9:0] m_acc = 10'h3FF, m_step = 10'h3FF;
    logic [1:0] m_dm = 2'b01, m_sc = 2'b00;
    logic       m_sm = 0, m_dis = 0, m_hwen = 0, m_ack = 0;

    frac_clk_div uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .susp_req_i(req), .susp_ack_o(ack), .hw_en_i(hw_en), .tick_o(tick)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] mk(input bit dis, input bit hwen, input logic [1:0] dm,
                                       input logic [1:0] sc, input bit sm, input logic [9:0] st);
        return {dis, hwen, 14'b0, dm, sc, sm, 1'b0, st};
    endfunction

    // One model step for the coming edge, queue the result, then clock it.
    task automatic step_cycle(input bit wr, input logic [31:0] wd, input string tag);
        logic et;
        logic ok, mon, son, act, cy;
        logic [10:0] sum;
        et = 0;
        if (wr) begin
            m_acc = wd[9:0]; m_step = wd[9:0]; m_dm = wd[15:14]; m_sc = wd[13:12];
            m_sm = wd[11]; m_dis = wd[31]; m_hwen = wd[30]; m_ack = 0;
        end else begin
            ok  = m_hwen ? hw_en : !m_dis;
            mon = (m_dm == 2'b01) || (m_dm == 2'b10);
            son = (m_sc != 2'b00);
            act = mon && ok && !m_ack && !(son && m_sm && req);
            sum = {1'b0, m_acc} + ((m_dm == 2'b10) ? {1'b0, m_step} : 11'd1);
            cy  = sum[10];
            if (act) begin
                m_acc = (m_dm == 2'b01 && cy) ? m_step : sum[9:0];
                et = cy;
            end
            if (!son || !req)  m_ack = 0;
            else if (m_ack)    m_ack = 1;
            else if (m_sm)     m_ack = 1;
            else               m_ack = act && cy;
        end
        exp_q.push_back({et, m_ack});
        tag_q.push_back(tag);
        wr_en = wr;
        wdata = wd;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic run_n(input int n, input string tag);
        for (int i = 0; i < n; i++) step_cycle(0, '0, tag);
    endtask

    task automatic chk_reg(input string tag);
        logic [31:0] e;
        e = {m_dis, m_hwen, req, m_ack, 2'b0, m_acc, m_dm, m_sc, m_sm, 1'b0, m_step};
        checks++;
        if (rdata !== e) begin
            errors++;
            $display("FAIL %s rdata actual %h expected %h", tag, rdata, e);
        end
    endtask

    // Monitor: compare strobe and acknowledge just after each edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({tick, ack} !== e) begin
                errors++;
                $display("FAIL %s tick/ack actual %b%b expected %b%b", t, tick, ack, e[1], e[0]);
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk_reg("R1");
        checks++;
        if (tick !== 0 || ack !== 0) begin
            errors++;
            $display("FAIL R1 tick/ack actual %b%b expected 00", tick, ack);
        end
        run_n(6, "R4 step 1023 every cycle");
        chk_reg("R4");

        step_cycle(1, mk(0, 0, 2'b01, 2'b00, 0, 10'd1020), "R3 write");
        chk_reg("R3");
        run_n(14, "R4 reload period 4");
        step_cycle(1, mk(0, 0, 2'b01, 2'b00, 0, 10'd1017), "R3 write");
        run_n(22, "R4 reload period 7");

        // R2: read-only bits set in write data have no effect
        step_cycle(1, mk(0, 0, 2'b01, 2'b00, 0, 10'd1000) | 32'h3FFF_0400, "R2 ro write");
        chk_reg("R2");

        step_cycle(1, mk(0, 0, 2'b10, 2'b00, 0, 10'd256), "R3 write");
        run_n(16, "R5 frac 256");
        step_cycle(1, mk(0, 0, 2'b10, 2'b00, 0, 10'd384), "R3 write");
        run_n(24, "R5 frac 384");
        step_cycle(1, mk(0, 0, 2'b10, 2'b00, 0, 10'd1023), "R3 write");
        run_n(8, "R5 frac 1023");
        chk_reg("R5");

        step_cycle(1, mk(0, 0, 2'b10, 2'b00, 0, 10'd300), "R3 write");
        run_n(2, "R5");
        step_cycle(1, mk(0, 0, 2'b00, 2'b00, 0, 10'd1023), "R6 off 00");
        run_n(8, "R6 mode 00");
        chk_reg("R6");
        step_cycle(1, mk(0, 0, 2'b11, 2'b00, 0, 10'd1023), "R6 off 11");
        run_n(8, "R6 mode 11");
        chk_reg("R6");

        step_cycle(1, mk(1, 0, 2'b01, 2'b00, 0, 10'd1022), "R7 dis");
        run_n(8, "R7 disabled");
        chk_reg("R7");
        hw_en = 1;
        step_cycle(1, mk(1, 1, 2'b01, 2'b00, 0, 10'd1022), "R7 hw");
        run_n(8, "R7 hw enable on");
        hw_en = 0;
        run_n(6, "R7 hw enable off");
        chk_reg("R7");
        hw_en = 1;
        run_n(4, "R7 hw enable back on");

        step_cycle(1, mk(0, 0, 2'b01, 2'b00, 1, 10'd1021), "R8 write");
        req = 1;
        run_n(10, "R8 suspend ignored");
        chk_reg("R8");
        req = 0;

        step_cycle(1, mk(0, 0, 2'b01, 2'b01, 1, 10'd1020), "R9 write");
        run_n(2, "R9 before");
        req = 1;
        run_n(8, "R9 immediate");
        chk_reg("R9");
        req = 0;
        run_n(8, "R11 release");

        step_cycle(1, mk(0, 0, 2'b10, 2'b10, 0, 10'd100), "R10 write");
        req = 1;
        run_n(20, "R10 granted");
        chk_reg("R10");
        req = 0;
        run_n(15, "R11 resume");
        chk_reg("R11");

        step_cycle(1, mk(0, 0, 2'b01, 2'b11, 0, 10'd1023), "R12 write");
        run_n(3, "R12 strobe");
        req = 1;
        run_n(4, "R12 granted frozen");
        req = 0;
        run_n(4, "R12 resume");

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule